// File: doc/BRIEF.md
# Path Difficulty Tracking Cache

This block learns, while the program runs, which control-flow paths end in a branch that the hardware predictor keeps getting wrong. Each retired branch arrives as a path identifier and a flag that says whether the predictor missed it. The identifier is computed upstream. The block looks the identifier up in a set-associative table. Each entry counts how often its path occurs and how often the branch that ends the path was mispredicted. Once per fixed window of occurrences, the entry decides whether the path is difficult.

A path that is difficult and not yet handed off raises a promotion request toward a downstream builder. The builder answers with accept or busy. An accepted entry is marked as promoted. When a promoted path stops being difficult, the block emits a one-cycle demotion event that carries the path identifier. Entries are allocated only for mispredicted branches. Replacement spares entries marked difficult, so the limited storage stays focused on the paths that matter.

Top module: `path_diff_cache`

## Requirements
- R1: The set index is the low SET_BITS bits of the path identifier and the tag is the remaining upper bits. An update counts toward an existing entry only when both the set and the full tag match.
- R2: On a miss, a new entry is allocated only when upd_mispred is 1. The new entry starts with one occurrence and one misprediction. A correctly predicted miss leaves the table unchanged.
- R3: When an entry's occurrence count reaches INTERVAL (default 32), its Difficult flag is set to (mispredictions × thr_den > INTERVAL × thr_num). Both counters then restart from zero.
- R4: The victim is chosen in this order: an invalid way first, then the least recently used way whose Difficult flag is clear, and only when every way is difficult, the least recently used way. A hit or an allocation makes that way the most recently used.
- R5: promo_req rises on the clock edge that processes an update which leaves the entry Difficult and not promoted, provided no request is already outstanding. promo_path then carries that update's path identifier.
- R6: Once raised, promo_req and promo_path hold until promo_ack or promo_busy is seen. A request drops on the edge after either answer.
- R7: promo_ack marks the entry as promoted, and further updates of that entry raise no request while it stays promoted.
- R8: promo_busy leaves the entry unpromoted, so the next update of that entry raises the request again.
- R9: When an interval ends that changes a promoted entry's Difficult flag from 1 to 0, demote_evt is 1 for one cycle with demote_path equal to the path identifier, and the entry becomes unpromoted.
- R10: While rst_n is 0 at a clock edge, the table is emptied and promo_req and demote_evt are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_valid | input | 1 | One retired branch this cycle |
| upd_path | input | PATH_W | Path identifier of the retired branch |
| upd_mispred | input | 1 | The hardware predictor was wrong for this branch |
| thr_num | input | THR_W | Numerator of the difficulty threshold |
| thr_den | input | THR_W | Denominator of the difficulty threshold |
| promo_req | output | 1 | Promotion request to the builder |
| promo_path | output | PATH_W | Path identifier of the pending request |
| promo_ack | input | 1 | Builder accepts the pending request |
| promo_busy | input | 1 | Builder refuses the pending request |
| demote_evt | output | 1 | One-cycle demotion event |
| demote_path | output | PATH_W | Path identifier of the demoted entry |

## Verification
The assertions assume a well-behaved builder. It answers only while a request is raised, and it never asserts accept and busy in the same cycle. The bench drives promo_ack and promo_busy only after it has seen promo_req high, and it pulses exactly one of them for a single cycle. It also keeps thr_num and thr_den constant while updates are in flight. All internal state is observed through the request and demotion outputs. Sequences are therefore sized so that the interval boundary lands on a known update, and each hit, miss, eviction or tag mismatch changes whether or when a request or event appears.

// File: rtl/path_diff_pkg.sv
// Package: shared types for the path difficulty tracking cache.
// Assumes nothing beyond standard SystemVerilog.
package path_diff_pkg;

    // State of the promotion handshake toward the builder.
    typedef enum logic {
        PR_IDLE = 1'b0,
        PR_WAIT = 1'b1
    } promo_state_e;

endpackage

// File: rtl/path_diff_lru.sv
// Module: path_diff_lru
// Picks a victim way for one set and computes that set's next age vector.
// Age 0 is the most recent way and WAYS-1 the oldest. The ages in a set
// always form a permutation of 0..WAYS-1. Assumes WAYS >= 2.
module path_diff_lru #(
    parameter int WAYS = 4,
    parameter int AW   = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]         valid,
    input  logic [WAYS-1:0]         diff,
    input  logic [WAYS-1:0][AW-1:0] ages_in,
    input  logic                    hit,
    input  logic [AW-1:0]           hit_way,
    output logic [AW-1:0]           victim,
    output logic [WAYS-1:0][AW-1:0] ages_out
);

    logic          inv_found;
    logic [AW-1:0] inv_way;
    logic          nd_found;
    logic [AW-1:0] nd_way;
    logic [AW-1:0] nd_age;
    logic [AW-1:0] old_way;
    logic [AW-1:0] acc_way;
    logic [AW-1:0] acc_age;

    // Find the first invalid way.
    always_comb begin
        inv_found = 1'b0;
        inv_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!valid[w] && !inv_found) begin
                inv_found = 1'b1;
                inv_way   = AW'(w);
            end
        end
    end

    // Find the oldest way among those not marked difficult.
    always_comb begin
        nd_found = 1'b0;
        nd_way   = '0;
        nd_age   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!diff[w] && (!nd_found || ages_in[w] > nd_age)) begin
                nd_found = 1'b1;
                nd_way   = AW'(w);
                nd_age   = ages_in[w];
            end
        end
    end

    // Find the oldest way overall.
    always_comb begin
        old_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (ages_in[w] == AW'(WAYS - 1)) begin
                old_way = AW'(w);
            end
        end
    end

    // Victim priority: invalid, then oldest non-difficult, then oldest.
    always_comb begin
        if (inv_found) begin
            victim = inv_way;
        end else if (nd_found) begin
            victim = nd_way;
        end else begin
            victim = old_way;
        end
    end

    // Move the accessed way to age 0 and age every way that was younger.
    always_comb begin
        acc_way = hit ? hit_way : victim;
        acc_age = ages_in[acc_way];
        for (int w = 0; w < WAYS; w++) begin
            if (AW'(w) == acc_way) begin
                ages_out[w] = '0;
            end else if (ages_in[w] < acc_age) begin
                ages_out[w] = ages_in[w] + 1'b1;
            end else begin
                ages_out[w] = ages_in[w];
            end
        end
    end

endmodule

// File: rtl/path_diff_judge.sv
// Module: path_diff_judge
// Computes the next counters and flags for one entry after a single update.
// The difficulty test avoids a divider by cross-multiplying the counts with
// the threshold fraction. Assumes INTERVAL >= 2 and that the caller passes
// zeroed state for an allocation.
module path_diff_judge #(
    parameter int INTERVAL = 32,
    parameter int OCC_W    = $clog2(INTERVAL + 1),
    parameter int THR_W    = 8
) (
    input  logic [OCC_W-1:0] in_occ,
    input  logic [OCC_W-1:0] in_mis,
    input  logic             in_diff,
    input  logic             in_prom,
    input  logic             mispred,
    input  logic [THR_W-1:0] thr_num,
    input  logic [THR_W-1:0] thr_den,
    output logic [OCC_W-1:0] out_occ,
    output logic [OCC_W-1:0] out_mis,
    output logic             out_diff,
    output logic             out_prom,
    output logic             demote
);

    localparam int MUL_W = OCC_W + THR_W;
    localparam logic [OCC_W-1:0] LIMIT = OCC_W'(INTERVAL);

    logic [OCC_W-1:0] occ_inc;
    logic [OCC_W-1:0] mis_inc;
    logic             win_end;
    logic [MUL_W-1:0] lhs;
    logic [MUL_W-1:0] rhs;
    logic             verdict;

    // Saturating increments, so a count can never wrap inside a window.
    always_comb begin
        occ_inc = (in_occ >= LIMIT) ? LIMIT : in_occ + 1'b1;
        mis_inc = (mispred && in_mis < LIMIT) ? in_mis + 1'b1 : in_mis;
    end

    // Threshold comparison without division.
    always_comb begin
        win_end = (occ_inc == LIMIT);
        lhs     = MUL_W'(mis_inc) * MUL_W'(thr_den);
        rhs     = MUL_W'(INTERVAL) * MUL_W'(thr_num);
        verdict = (lhs > rhs);
    end

    // Next state: restart the counters at the window end and latch the verdict.
    always_comb begin
        if (win_end) begin
            out_occ  = '0;
            out_mis  = '0;
            out_diff = verdict;
        end else begin
            out_occ  = occ_inc;
            out_mis  = mis_inc;
            out_diff = in_diff;
        end
        demote   = win_end && in_diff && !verdict && in_prom;
        out_prom = in_prom && !demote;
    end

endmodule

// File: rtl/path_diff_promo.sv
// Module: path_diff_promo
// Holds at most one promotion request toward the builder. The request stays
// up until the builder answers with accept or busy. Assumes the two answers
// are never asserted together.
module path_diff_promo
    import path_diff_pkg::*;
#(
    parameter int PATH_W = 32,
    parameter int AW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand,
    input  logic [PATH_W-1:0] cand_path,
    input  logic [AW-1:0]     cand_way,
    input  logic              promo_ack,
    input  logic              promo_busy,
    output logic              promo_req,
    output logic [PATH_W-1:0] promo_path,
    output logic [AW-1:0]     pend_way,
    output logic              accept
);

    promo_state_e state_q;

    // Handshake state and the latched request contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PR_IDLE;
            promo_path <= '0;
            pend_way   <= '0;
        end else begin
            case (state_q)
                PR_IDLE: begin
                    if (cand) begin
                        state_q    <= PR_WAIT;
                        promo_path <= cand_path;
                        pend_way   <= cand_way;
                    end
                end
                default: begin
                    if (promo_ack || promo_busy) begin
                        state_q <= PR_IDLE;
                    end
                end
            endcase
        end
    end

    // Request level and the accept strobe.
    always_comb begin
        promo_req = (state_q == PR_WAIT);
        accept    = (state_q == PR_WAIT) && promo_ack;
    end

endmodule

// File: rtl/path_diff_cache.sv
// Module: path_diff_cache (top)
// Set-associative table that learns which control-flow paths end in badly
// predicted branches. It processes one update per cycle, with a single-cycle
// read-modify-write of the addressed set. Assumes the path identifier is
// already hashed, WAYS >= 2 and INTERVAL >= 2.
module path_diff_cache #(
    parameter int PATH_W   = 32,
    parameter int SET_BITS = 9,
    parameter int WAYS     = 4,
    parameter int INTERVAL = 32,
    parameter int THR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [PATH_W-1:0] upd_path,
    input  logic              upd_mispred,
    input  logic [THR_W-1:0]  thr_num,
    input  logic [THR_W-1:0]  thr_den,
    output logic              promo_req,
    output logic [PATH_W-1:0] promo_path,
    input  logic              promo_ack,
    input  logic              promo_busy,
    output logic              demote_evt,
    output logic [PATH_W-1:0] demote_path
);

    localparam int SETS  = 1 << SET_BITS;
    localparam int TAG_W = PATH_W - SET_BITS;
    localparam int AW    = $clog2(WAYS);
    localparam int OCC_W = $clog2(INTERVAL + 1);

    // Entry storage.
    logic [WAYS-1:0]         v_q   [SETS];
    logic [WAYS-1:0]         d_q   [SETS];
    logic [WAYS-1:0]         p_q   [SETS];
    logic [WAYS-1:0][AW-1:0] age_q [SETS];
    logic [TAG_W-1:0]        tag_q [SETS][WAYS];
    logic [OCC_W-1:0]        occ_q [SETS][WAYS];
    logic [OCC_W-1:0]        mis_q [SETS][WAYS];

    logic [SET_BITS-1:0] set_idx;
    logic [TAG_W-1:0]    tag_in;
    logic [WAYS-1:0]     hit_vec;
    logic                hit;
    logic [AW-1:0]       hit_way;
    logic [AW-1:0]       victim;
    logic [AW-1:0]       way_sel;
    logic [WAYS-1:0][AW-1:0] ages_nxt;
    logic                alloc;
    logic                wr;

    logic [OCC_W-1:0] j_in_occ, j_in_mis, j_out_occ, j_out_mis;
    logic             j_in_diff, j_in_prom, j_out_diff, j_out_prom, j_demote;

    logic                cand;
    logic [AW-1:0]       pend_way;
    logic                accept;
    logic [SET_BITS-1:0] pend_set;
    logic [TAG_W-1:0]    pend_tag;
    logic                ack_apply;
    logic                ack_merge;

    // Split the path identifier into set index and tag.
    always_comb begin
        set_idx = upd_path[SET_BITS-1:0];
        tag_in  = upd_path[PATH_W-1:SET_BITS];
    end

    // Per-way tag comparators.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = v_q[set_idx][w] && (tag_q[set_idx][w] == tag_in);
    end

    // Encode the hitting way.
    always_comb begin
        hit     = |hit_vec;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_way = AW'(w);
            end
        end
    end

    path_diff_lru #(
        .WAYS (WAYS),
        .AW   (AW)
    ) u_lru (
        .valid    (v_q[set_idx]),
        .diff     (d_q[set_idx]),
        .ages_in  (age_q[set_idx]),
        .hit      (hit),
        .hit_way  (hit_way),
        .victim   (victim),
        .ages_out (ages_nxt)
    );

    // Decide whether this update touches the table, and which way.
    always_comb begin
        alloc   = upd_valid && !hit && upd_mispred;
        wr      = upd_valid && (hit || alloc);
        way_sel = hit ? hit_way : victim;
    end

    // Check that a builder accept still refers to a live, difficult entry.
    always_comb begin
        pend_set  = promo_path[SET_BITS-1:0];
        pend_tag  = promo_path[PATH_W-1:SET_BITS];
        ack_apply = accept && v_q[pend_set][pend_way] &&
                    (tag_q[pend_set][pend_way] == pend_tag) &&
                    d_q[pend_set][pend_way];
        ack_merge = ack_apply && hit && (pend_set == set_idx) &&
                    (pend_way == way_sel);
    end

    // Feed the judge with the stored state on a hit, or zeros on allocation.
    always_comb begin
        if (hit) begin
            j_in_occ  = occ_q[set_idx][way_sel];
            j_in_mis  = mis_q[set_idx][way_sel];
            j_in_diff = d_q[set_idx][way_sel];
            j_in_prom = p_q[set_idx][way_sel] || ack_merge;
        end else begin
            j_in_occ  = '0;
            j_in_mis  = '0;
            j_in_diff = 1'b0;
            j_in_prom = 1'b0;
        end
    end

    path_diff_judge #(
        .INTERVAL (INTERVAL),
        .OCC_W    (OCC_W),
        .THR_W    (THR_W)
    ) u_judge (
        .in_occ   (j_in_occ),
        .in_mis   (j_in_mis),
        .in_diff  (j_in_diff),
        .in_prom  (j_in_prom),
        .mispred  (upd_mispred),
        .thr_num  (thr_num),
        .thr_den  (thr_den),
        .out_occ  (j_out_occ),
        .out_mis  (j_out_mis),
        .out_diff (j_out_diff),
        .out_prom (j_out_prom),
        .demote   (j_demote)
    );

    // A promotion candidate is a touched entry left difficult and unpromoted.
    always_comb begin
        cand = wr && j_out_diff && !j_out_prom;
    end

    path_diff_promo #(
        .PATH_W (PATH_W),
        .AW     (AW)
    ) u_promo (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand       (cand),
        .cand_path  (upd_path),
        .cand_way   (way_sel),
        .promo_ack  (promo_ack),
        .promo_busy (promo_busy),
        .promo_req  (promo_req),
        .promo_path (promo_path),
        .pend_way   (pend_way),
        .accept     (accept)
    );

    // Table state: reset, builder accepts, then the update write, which wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                v_q[s] <= '0;
                d_q[s] <= '0;
                p_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= AW'(w);
                    tag_q[s][w] <= '0;
                    occ_q[s][w] <= '0;
                    mis_q[s][w] <= '0;
                end
            end
        end else begin
            if (ack_apply) begin
                p_q[pend_set][pend_way] <= 1'b1;
            end
            if (wr) begin
                v_q[set_idx][way_sel]   <= 1'b1;
                tag_q[set_idx][way_sel] <= tag_in;
                occ_q[set_idx][way_sel] <= j_out_occ;
                mis_q[set_idx][way_sel] <= j_out_mis;
                d_q[set_idx][way_sel]   <= j_out_diff;
                p_q[set_idx][way_sel]   <= j_out_prom;
                age_q[set_idx]          <= ages_nxt;
            end
        end
    end

    // Registered demotion event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            demote_evt  <= 1'b0;
            demote_path <= '0;
        end else begin
            demote_evt <= wr && j_demote;
            if (wr && j_demote) begin
                demote_path <= upd_path;
            end
        end
    end

endmodule

// File: rtl/path_diff_cache_chk.sv
// Module: path_diff_cache_chk
// Port-level protocol checks for path_diff_cache, attached by bind.
// Assumes a builder that answers only a raised request and never with both
// answers at once.
module path_diff_cache_chk #(
    parameter int PATH_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_valid,
    input logic [PATH_W-1:0] upd_path,
    input logic              promo_req,
    input logic [PATH_W-1:0] promo_path,
    input logic              promo_ack,
    input logic              promo_busy,
    input logic              demote_evt,
    input logic [PATH_W-1:0] demote_path
);

    logic past_ok;
    logic was_rst = 1'b0;

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
        was_rst <= !rst_n;
    end

    assert_answer_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(promo_ack && promo_busy));

    assert_answer_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (promo_ack || promo_busy) |-> promo_req);

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (promo_req && !promo_ack && !promo_busy) |=> (promo_req && $stable(promo_path)));

    assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (promo_req && (promo_ack || promo_busy)) |=> !promo_req);

    assert_req_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(promo_req)) |-> ($past(upd_valid) && promo_path == $past(upd_path)));

    assert_demote_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && demote_evt) |-> ($past(upd_valid) && demote_path == $past(upd_path)));

    assert_reset_quiet_R10: assert property (@(posedge clk)
        was_rst |-> (!promo_req && !demote_evt));

endmodule

bind path_diff_cache path_diff_cache_chk #(
    .PATH_W (PATH_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_valid   (upd_valid),
    .upd_path    (upd_path),
    .promo_req   (promo_req),
    .promo_path  (promo_path),
    .promo_ack   (promo_ack),
    .promo_busy  (promo_busy),
    .demote_evt  (demote_evt),
    .demote_path (demote_path)
);

// File: tb/path_diff_cache_bench.sv
`timescale 1ns/1ps
// Bench for path_diff_cache: a vector table walked by one loop, then
// directed tests for the handshake, threshold, replacement and reset.
module path_diff_cache_bench;

    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          upd_valid = 1'b0;
    logic [PW-1:0] upd_path = '0;
    logic          upd_mispred = 1'b0;
    logic [7:0]    thr_num = 8'd1;
    logic [7:0]    thr_den = 8'd4;
    logic          promo_req;
    logic [PW-1:0] promo_path;
    logic          promo_ack = 1'b0;
    logic          promo_busy = 1'b0;
    logic          demote_evt;
    logic [PW-1:0] demote_path;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    path_diff_cache #(
        .PATH_W   (PW),
        .SET_BITS (2),
        .WAYS     (4),
        .INTERVAL (32),
        .THR_W    (8)
    ) u_path_diff_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_valid   (upd_valid),
        .upd_path    (upd_path),
        .upd_mispred (upd_mispred),
        .thr_num     (thr_num),
        .thr_den     (thr_den),
        .promo_req   (promo_req),
        .promo_path  (promo_path),
        .promo_ack   (promo_ack),
        .promo_busy  (promo_busy),
        .demote_evt  (demote_evt),
        .demote_path (demote_path)
    );

    // Row: {req tag, path, mispredicted, update count, expected promo_req}
    localparam int NV = 4;
    localparam logic [36:0] VECS [NV] = '{
        {4'd2, PW'(16'h0032), 1'b0, 15'd1,  1'b0},  // R2 correct miss, no entry
        {4'd2, PW'(16'h0032), 1'b1, 15'd31, 1'b0},  // R2 one short of a window
        {4'd1, PW'(16'h0132), 1'b0, 15'd1,  1'b0},  // R1 same set, other tag
        {4'd3, PW'(16'h0032), 1'b1, 15'd1,  1'b1}   // R3 window closes, difficult
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [PW-1:0] p, input logic m, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            upd_valid   = 1'b1;
            upd_path    = p;
            upd_mispred = m;
        end
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic answer(input logic acc);
        promo_ack  = acc;
        promo_busy = !acc;
        @(negedge clk);
        promo_ack  = 1'b0;
        promo_busy = 1'b0;
    endtask

    initial begin : watchdog
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R10 req after reset", 32'(promo_req), 32'd0);
        check("R10 demote after reset", 32'(demote_evt), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk.
        for (int v = 0; v < NV; v++) begin
            send(VECS[v][32:17], VECS[v][16], int'(VECS[v][15:1]));
            check($sformatf("R%0d vector %0d", VECS[v][36:33], v),
                  32'(promo_req), 32'(VECS[v][0]));
            if (promo_req) answer(1'b1);
        end

        // R5: request raised with the path.
        send(16'h0010, 1'b1, 32);
        check("R5 request raised", 32'(promo_req), 32'd1);
        check("R5 request path", 32'(promo_path), 32'h0010);
        // R6: request held without an answer.
        repeat (3) @(negedge clk);
        check("R6 request held", 32'(promo_req), 32'd1);
        answer(1'b1);
        check("R6 request dropped after accept", 32'(promo_req), 32'd0);
        // R7: promoted entry stays quiet.
        send(16'h0010, 1'b1, 32);
        check("R7 no request while promoted", 32'(promo_req), 32'd0);
        // R9: demotion event.
        send(16'h0010, 1'b0, 32);
        check("R9 demote event", 32'(demote_evt), 32'd1);
        check("R9 demote path", 32'(demote_path), 32'h0010);
        @(negedge clk);
        check("R9 demote one cycle", 32'(demote_evt), 32'd0);
        send(16'h0010, 1'b1, 32);
        check("R9 promoted cleared, re-request", 32'(promo_req), 32'd1);
        // R8: refusal and re-raise.
        answer(1'b0);
        check("R8 request dropped after busy", 32'(promo_req), 32'd0);
        send(16'h0010, 1'b1, 1);
        check("R8 request raised again", 32'(promo_req), 32'd1);
        answer(1'b1);

        // R3: threshold boundary at 1/2.
        thr_num = 8'd1;
        thr_den = 8'd2;
        send(16'h0021, 1'b1, 16);
        send(16'h0021, 1'b0, 16);
        check("R3 16 of 32 not difficult", 32'(promo_req), 32'd0);
        send(16'h0021, 1'b0, 15);
        send(16'h0021, 1'b1, 17);
        check("R3 17 of 32 difficult", 32'(promo_req), 32'd1);
        answer(1'b1);
        thr_num = 8'd1;
        thr_den = 8'd4;

        // R4: LRU order in set 3.
        send(16'h0003, 1'b1, 1);
        send(16'h0103, 1'b1, 1);
        send(16'h0203, 1'b1, 1);
        send(16'h0303, 1'b1, 1);
        send(16'h0003, 1'b1, 1);
        send(16'h0403, 1'b1, 1);
        send(16'h0103, 1'b1, 31);
        check("R4 LRU way was evicted", 32'(promo_req), 32'd0);
        send(16'h0003, 1'b1, 30);
        check("R4 recently used way kept", 32'(promo_req), 32'd1);
        answer(1'b1);
        // R4: difficult way survives while oldest.
        send(16'h0503, 1'b1, 1);
        send(16'h0603, 1'b1, 1);
        send(16'h0703, 1'b1, 1);
        send(16'h0803, 1'b1, 1);
        send(16'h0003, 1'b0, 32);
        check("R4 difficult way protected", 32'(demote_evt), 32'd1);
        check("R4 protected way path", 32'(demote_path), 32'h0003);

        // R10: reset empties the table.
        send(16'h0022, 1'b1, 31);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 req during reset", 32'(promo_req), 32'd0);
        rst_n = 1'b1;
        send(16'h0022, 1'b1, 1);
        check("R10 counts cleared", 32'(promo_req), 32'd0);
        send(16'h0022, 1'b1, 31);
        check("R10 fresh window", 32'(promo_req), 32'd1);
        answer(1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule